// File: doc/BRIEF.md
# Redundant Reference Switchover Controller

This block decides which of two redundant timing references, primary or secondary, feeds a telecom PLL. A host writes three small control registers through a single-cycle write port and can read them back. With automatic switching off, the reference in use is simply the one the host selects. With automatic switching on, the block moves to the other reference on its own. The trigger for that move is configurable: either the active reference being reported lost, or the PLL entering holdover.

The block also drives the PLL operating mode (normal, holdover, free-run), the loop-bandwidth choice, the reference-frequency choice and a PLL reset level. It turns a low-to-high transition of a realign control bit into a single-cycle realign strobe. Reference loss and holdover arrive as plain synchronous digital inputs.

Register addresses: 0 is the switching register, 1 the reference register, 2 the reset register. Address 3 reads as zero and ignores writes.

Top module: `refsw_ctrl`

## Requirements
- R1: After reset all control fields are zero. The primary reference (active_ref = 0) is in use, pll_mode is normal (00), realign_stb, pll_rst, loop_bw_narrow and ref_freq_high are 0, and register 1 reads 0x00.
- R2: While automatic switching is off (address 0 bit 7 = 0), active_ref equals register 1 bit 0 (0 primary, 1 secondary) from the cycle after the write. pri_lost and sec_lost have no effect.
- R3: Reading address 1 returns the reference in use at bit 3, the manual select at bit 0 and the frequency select at bit 1. Reading address 0 returns bits 7..2 as written. Reading address 2 returns the reset bit at bit 1. All other bits read 0.
- R4: With automatic switching on and the trigger bit (address 0 bit 6) at 0, a loss indication on the active reference moves active_ref to the other reference at the next clock edge, provided that reference is not lost.
- R5: With the trigger bit at 1, only a rising edge of pll_holdover moves active_ref, once per edge. Holdover held high causes no further moves, and loss of the active reference alone causes none.
- R6: The block never moves to a reference that is reported lost in the cycle of the trigger. When both references are lost, active_ref holds.
- R7: While automatic switching is on, writes to the manual select leave active_ref unchanged. Clearing bit 7 makes active_ref follow the manual select from the cycle after that write.
- R8: Address 0 bits 5:4 set pll_mode: 00 normal, 01 holdover, 10 free-run. The unused code 11 drives free-run (10). Writes to other addresses leave the mode unchanged.
- R9: Address 0 bit 2 drives loop_bw_narrow (1 = narrow 6 Hz, 0 = 12 Hz). Address 1 bit 1 drives ref_freq_high (1 = 19.44 MHz, 0 = 8 kHz). Address 2 bit 1 drives pll_rst.
- R10: A write that takes address 0 bit 3 from 0 to 1 produces realign_stb high for exactly one cycle, beginning one clock after the write. Writing 1 again, or writing 0, produces no strobe.
- R11: A realign strobe and an automatic switchover falling in the same cycle both take effect, and neither suppresses the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| pri_lost | input | 1 | Primary reference loss indication |
| sec_lost | input | 1 | Secondary reference loss indication |
| pll_holdover | input | 1 | PLL holdover indication |
| active_ref | output | 1 | Reference in use: 0 primary, 1 secondary |
| pll_mode | output | 2 | PLL mode: 00 normal, 01 holdover, 10 free-run |
| loop_bw_narrow | output | 1 | Loop bandwidth select |
| ref_freq_high | output | 1 | Reference frequency select |
| realign_stb | output | 1 | One-cycle realign request |
| pll_rst | output | 1 | PLL reset level |

## Verification
The realign strobe and an automatic switchover can land in the same cycle, because one is driven by a register write and the other by a loss input. The bench writes the switching register so that automatic switching and the realign bit both turn on. In the next cycle it raises the loss flag of the active reference, so the flip and the strobe occur on the same edge. Both active_ref and realign_stb are then sampled in that one cycle and must show the new reference and a high strobe. One cycle later the strobe must have dropped while the reference holds.

// File: rtl/refsw_pkg.sv
// Package: shared widths, register addresses, bit positions and the
// control-state record for the reference switchover controller.
// Assumes an 8-bit register file with a 2-bit address.
package refsw_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_SW  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_REF = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RST = 2'd2;

    // switching register bit positions
    localparam int B_HW_EN    = 7;
    localparam int B_TRIG     = 6;
    localparam int B_MODE_HI  = 5;
    localparam int B_MODE_LO  = 4;
    localparam int B_REALIGN  = 3;
    localparam int B_BW       = 2;
    // reference register bit positions
    localparam int B_MANUAL   = 0;
    localparam int B_FREQ     = 1;
    localparam int B_ACTIVE   = 3;
    // reset register bit position
    localparam int B_PLLRST   = 1;

    typedef enum logic [1:0] {
        PLL_NORMAL = 2'b00,
        PLL_HOLD   = 2'b01,
        PLL_FREE   = 2'b10
    } pll_mode_t;

    typedef struct packed {
        logic       hw_en;
        logic       trig_hold;
        logic [1:0] mode_code;
        logic       realign;
        logic       bw_narrow;
        logic       manual_sel;
        logic       freq_high;
        logic       pll_rst;
    } ctrl_t;

    // Maps a raw mode code to the driven mode; the unused code selects free-run.
    function automatic pll_mode_t map_mode(input logic [1:0] code);
        case (code)
            2'b00:   return PLL_NORMAL;
            2'b01:   return PLL_HOLD;
            default: return PLL_FREE;
        endcase
    endfunction
endpackage

// File: rtl/refsw_regs.sv
// Control register file. Holds the switching, reference and reset registers,
// accepts single-cycle writes and returns a combinational read word. Bits that
// have no field read as zero and ignore writes. Assumes writes are already
// synchronous to clk.
module refsw_regs
    import refsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              active_ref,
    output logic [REG_W-1:0]  rdata,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;

    // Register update: each address writes only its own fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we) begin
            case (addr)
                ADDR_SW: begin
                    ctrl_q.hw_en     <= wdata[B_HW_EN];
                    ctrl_q.trig_hold <= wdata[B_TRIG];
                    ctrl_q.mode_code <= wdata[B_MODE_HI:B_MODE_LO];
                    ctrl_q.realign   <= wdata[B_REALIGN];
                    ctrl_q.bw_narrow <= wdata[B_BW];
                end
                ADDR_REF: begin
                    ctrl_q.manual_sel <= wdata[B_MANUAL];
                    ctrl_q.freq_high  <= wdata[B_FREQ];
                end
                ADDR_RST: begin
                    ctrl_q.pll_rst <= wdata[B_PLLRST];
                end
                default: ;
            endcase
        end
    end

    // Read mux: assembles the addressed register, inserting live status.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_SW: begin
                rdata[B_HW_EN]              = ctrl_q.hw_en;
                rdata[B_TRIG]               = ctrl_q.trig_hold;
                rdata[B_MODE_HI:B_MODE_LO]  = ctrl_q.mode_code;
                rdata[B_REALIGN]            = ctrl_q.realign;
                rdata[B_BW]                 = ctrl_q.bw_narrow;
            end
            ADDR_REF: begin
                rdata[B_MANUAL] = ctrl_q.manual_sel;
                rdata[B_FREQ]   = ctrl_q.freq_high;
                rdata[B_ACTIVE] = active_ref;
            end
            ADDR_RST: begin
                rdata[B_PLLRST] = ctrl_q.pll_rst;
            end
            default: rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;

    // R8: a write to another address never disturbs the mode code
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && ($past(addr) != ADDR_SW)) |-> $stable(ctrl_q.mode_code));

    // R2: the manual select only changes after a write to the reference register
    assert_manual_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.manual_sel != $past(ctrl_q.manual_sel)) |->
            ($past(we) && ($past(addr) == ADDR_REF)));
endmodule

// File: rtl/refsw_select.sv
// Reference selection engine. Tracks the manual select while automatic
// switching is off. When it is on, moves to the other reference on the chosen
// trigger (loss of the active reference, or a rising edge of holdover),
// but only when the other reference is not lost. Assumes loss and holdover
// inputs are synchronous to clk.
module refsw_select (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_en,
    input  logic trig_hold,
    input  logic manual_sel,
    input  logic pri_lost,
    input  logic sec_lost,
    input  logic holdover,
    output logic active_ref
);
    logic auto_q;
    logic hold_d;
    logic hold_rise;
    logic act_lost;
    logic alt_lost;
    logic trigger;
    logic flip;

    // Holdover history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_d <= 1'b0;
        else        hold_d <= holdover;
    end

    // Trigger decode: pick the configured condition and gate on the other reference.
    always_comb begin
        hold_rise = holdover & ~hold_d;
        act_lost  = auto_q ? sec_lost : pri_lost;
        alt_lost  = auto_q ? pri_lost : sec_lost;
        trigger   = trig_hold ? hold_rise : act_lost;
        flip      = trigger & ~alt_lost;
    end

    // Automatic selection state: shadows manual when off, toggles on a qualified trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)      auto_q <= 1'b0;
        else if (!hw_en) auto_q <= manual_sel;
        else if (flip)   auto_q <= ~auto_q;
    end

    // Output select: manual wins whenever automatic switching is off.
    assign active_ref = hw_en ? auto_q : manual_sel;

    // R6: an automatic move never lands on a reference that was lost at the trigger
    assert_no_switch_to_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hw_en) && (auto_q != $past(auto_q))) |->
            !(auto_q ? $past(sec_lost) : $past(pri_lost)));

    // R4: in loss mode the reference holds while the active one is healthy
    assert_hold_when_healthy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hw_en) && !$past(trig_hold) &&
         !($past(auto_q) ? $past(sec_lost) : $past(pri_lost))) |->
            (auto_q == $past(auto_q)));

    // R5: in holdover mode a steady holdover level causes no move
    assert_hold_level_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hw_en) && $past(trig_hold) && $past(hold_d) && $past(holdover)) |->
            (auto_q == $past(auto_q)));
endmodule

// File: rtl/refsw_realign.sv
// Realign strobe generator. Converts a low-to-high transition of the realign
// control level into a registered pulse one clock wide. Assumes the level is a
// register output in the same clock domain.
module refsw_realign (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic strobe
);
    logic level_d;
    logic strobe_q;

    // Edge capture: remember the level and register the rising-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d  <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            level_d  <= level;
            strobe_q <= level & ~level_d;
        end
    end

    assign strobe = strobe_q;

    // R10: the strobe is never longer than one cycle
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R10: every rise of the level is followed by a strobe
    assert_rise_gives_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |=> strobe);
endmodule

// File: rtl/refsw_ctrl.sv
// Top of the redundant reference switchover controller. Connects the register
// file, the selection engine and the realign strobe generator, and maps the
// stored fields onto the PLL control outputs. Assumes all inputs are
// synchronous to clk; reset is synchronous and active low.
module refsw_ctrl
    import refsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              pri_lost,
    input  logic              sec_lost,
    input  logic              pll_holdover,
    output logic              active_ref,
    output logic [1:0]        pll_mode,
    output logic              loop_bw_narrow,
    output logic              ref_freq_high,
    output logic              realign_stb,
    output logic              pll_rst
);
    ctrl_t ctrl;
    logic  act_ref;

    refsw_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .active_ref (act_ref),
        .rdata      (cfg_rdata),
        .ctrl       (ctrl)
    );

    refsw_select u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_en      (ctrl.hw_en),
        .trig_hold  (ctrl.trig_hold),
        .manual_sel (ctrl.manual_sel),
        .pri_lost   (pri_lost),
        .sec_lost   (sec_lost),
        .holdover   (pll_holdover),
        .active_ref (act_ref)
    );

    refsw_realign u_realign (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (ctrl.realign),
        .strobe (realign_stb)
    );

    // Output mapping from stored fields.
    always_comb begin
        active_ref     = act_ref;
        pll_mode       = map_mode(ctrl.mode_code);
        loop_bw_narrow = ctrl.bw_narrow;
        ref_freq_high  = ctrl.freq_high;
        pll_rst        = ctrl.pll_rst;
    end

    // R7: with automatic switching held on, manual writes do not move the output
    assert_manual_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl.hw_en) && ctrl.hw_en && !$past(pri_lost) && !$past(sec_lost) &&
         !$past(pll_holdover)) |-> $stable(active_ref));
endmodule

// File: tb/refsw_ctrl_tb_top.sv
// Directed bench for the reference switchover controller.
module refsw_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic       pri_lost = 1'b0;
    logic       sec_lost = 1'b0;
    logic       pll_holdover = 1'b0;
    logic       active_ref;
    logic [1:0] pll_mode;
    logic       loop_bw_narrow;
    logic       ref_freq_high;
    logic       realign_stb;
    logic       pll_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    refsw_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .pri_lost       (pri_lost),
        .sec_lost       (sec_lost),
        .pll_holdover   (pll_holdover),
        .active_ref     (active_ref),
        .pll_mode       (pll_mode),
        .loop_bw_narrow (loop_bw_narrow),
        .ref_freq_high  (ref_freq_high),
        .realign_stb    (realign_stb),
        .pll_rst        (pll_rst)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One-cycle write; returns at the falling edge after the write edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 active", {7'd0, active_ref}, 8'd0);
        check("R1 mode", {6'd0, pll_mode}, 8'd0);
        check("R1 strobe", {7'd0, realign_stb}, 8'd0);
        check("R1 outs", {5'd0, pll_rst, loop_bw_narrow, ref_freq_high}, 8'd0);
        rd(2'd1, v);
        check("R1 reg1", v, 8'h00);
    endtask

    task automatic t_manual();
        logic [7:0] v;
        wr(2'd1, 8'h01);
        check("R2 manual secondary", {7'd0, active_ref}, 8'd1);
        rd(2'd1, v);
        check("R3 readback active", v, 8'h09);
        pri_lost = 1'b0; sec_lost = 1'b1;
        tick(3);
        check("R2 loss ignored", {7'd0, active_ref}, 8'd1);
        sec_lost = 1'b0;
        wr(2'd1, 8'h00);
        check("R2 manual primary", {7'd0, active_ref}, 8'd0);
        pri_lost = 1'b1;
        tick(3);
        check("R2 pri loss ignored", {7'd0, active_ref}, 8'd0);
        pri_lost = 1'b0;
    endtask

    task automatic t_fields();
        logic [7:0] v;
        wr(2'd0, 8'h10); check("R8 holdover", {6'd0, pll_mode}, 8'd1);
        wr(2'd0, 8'h20); check("R8 freerun", {6'd0, pll_mode}, 8'd2);
        wr(2'd0, 8'h34); check("R8 code3 freerun", {6'd0, pll_mode}, 8'd2);
        check("R9 narrow bw", {7'd0, loop_bw_narrow}, 8'd1);
        rd(2'd0, v);     check("R3 reg0 readback", v, 8'h34);
        wr(2'd1, 8'h02); check("R9 freq high", {7'd0, ref_freq_high}, 8'd1);
        check("R8 mode kept", {6'd0, pll_mode}, 8'd2);
        wr(2'd2, 8'hFF); check("R9 pll reset", {7'd0, pll_rst}, 8'd1);
        rd(2'd2, v);     check("R3 reg2 readback", v, 8'h02);
        wr(2'd3, 8'hFF); rd(2'd3, v); check("R3 unused addr", v, 8'h00);
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        check("R8 normal", {6'd0, pll_mode}, 8'd0);
    endtask

    task automatic t_loss_switch();
        logic [7:0] v;
        wr(2'd0, 8'h80);
        pri_lost = 1'b1; tick(1);
        check("R4 to secondary", {7'd0, active_ref}, 8'd1);
        rd(2'd1, v); check("R3 active after auto", v, 8'h08);
        pri_lost = 1'b0; sec_lost = 1'b1; tick(1);
        check("R4 back to primary", {7'd0, active_ref}, 8'd0);
        pri_lost = 1'b1; tick(3);
        check("R6 both lost holds", {7'd0, active_ref}, 8'd0);
        sec_lost = 1'b0; tick(1);
        check("R6 moves once healthy", {7'd0, active_ref}, 8'd1);
        pri_lost = 1'b0; tick(2);
        check("R4 stays", {7'd0, active_ref}, 8'd1);
    endtask

    task automatic t_holdover_switch();
        wr(2'd0, 8'hC0);
        sec_lost = 1'b1; tick(2);
        check("R5 loss alone quiet", {7'd0, active_ref}, 8'd1);
        sec_lost = 1'b0;
        pll_holdover = 1'b1; tick(1);
        check("R5 edge switches", {7'd0, active_ref}, 8'd0);
        tick(3);
        check("R5 level quiet", {7'd0, active_ref}, 8'd0);
        pll_holdover = 1'b0; tick(1);
        sec_lost = 1'b1; pll_holdover = 1'b1; tick(1);
        check("R6 edge to lost ref", {7'd0, active_ref}, 8'd0);
        sec_lost = 1'b0; pll_holdover = 1'b0; tick(1);
    endtask

    task automatic t_manual_ignored();
        wr(2'd1, 8'h01);
        check("R7 manual ignored", {7'd0, active_ref}, 8'd0);
        wr(2'd0, 8'h00);
        check("R7 disable follows manual", {7'd0, active_ref}, 8'd1);
        tick(1);
        check("R7 stays manual", {7'd0, active_ref}, 8'd1);
    endtask

    task automatic t_realign();
        wr(2'd0, 8'h08);
        check("R10 not yet", {7'd0, realign_stb}, 8'd0);
        tick(1); check("R10 pulse", {7'd0, realign_stb}, 8'd1);
        tick(1); check("R10 one cycle", {7'd0, realign_stb}, 8'd0);
        wr(2'd0, 8'h08);
        tick(1); check("R10 rewrite one quiet", {7'd0, realign_stb}, 8'd0);
        wr(2'd0, 8'h00);
        tick(1); check("R10 clear quiet", {7'd0, realign_stb}, 8'd0);
    endtask

    task automatic t_concurrent();
        // manual is 1, so the automatic state starts on the secondary
        wr(2'd0, 8'h88);
        sec_lost = 1'b1; tick(1);
        check("R11 switch same cycle", {7'd0, active_ref}, 8'd0);
        check("R11 strobe same cycle", {7'd0, realign_stb}, 8'd1);
        sec_lost = 1'b0; tick(1);
        check("R11 strobe drops", {7'd0, realign_stb}, 8'd0);
        check("R11 ref holds", {7'd0, active_ref}, 8'd0);
        wr(2'd0, 8'h80); tick(1);
        check("R10 no strobe on clear", {7'd0, realign_stb}, 8'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_manual();
        t_fields();
        t_loss_switch();
        t_holdover_switch();
        t_manual_ignored();
        t_realign();
        t_concurrent();
        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule